// File: doc/BRIEF.md
# Bridge Address Translation Window Bank

This block holds the address-mapping windows of one direction of a bridge between two 32-bit buses. Eight windows are programmed through a small word-addressed register port. Each window has four stored words: a control word, a lower limit, an exclusive upper limit and an offset. Every lookup carries a 32-bit address and a mode word. The address is compared against all enabled windows whose access mode matches. One cycle later the block reports whether any window matched, which window was chosen, and the address translated into the other bus's space.

A parameter selects the outbound or the inbound variant. The two variants differ only in which control bits make up the compared mode field. The block does no bus cycles, no data movement and no byte swapping. It only decodes and translates.

Top module: `xlatWindows`

## Requirements
- R1: Register map, in word addresses. Window w (w < 4) occupies words `LO_BASE + 5*w` onward. Window w (w >= 4) occupies words `HI_BASE + 5*(w-4)` onward. The defaults are 0x40 and 0x68. Within a group, word +0 is control, +1 is lower limit, +2 is upper limit and +3 is offset. A write with `regWrEn` stores the full 32-bit value. `regRdData` combinationally returns the stored value, unmasked. Word +4 of a group and any address outside the groups read as 0, and writes to them are ignored.
- R2: After reset all stored words are 0, so every window is disabled. `resValid` and `resHit` are 0.
- R3: A window takes part in decode only while its control bit 31 is 1.
- R4: Windows 0 and 4 clear the low 12 bits of lower limit, upper limit and offset before use. All other windows clear the low 16 bits.
- R5: A window matches when lower <= address < upper, using the cleared values; the upper limit is exclusive. The translated address is address + offset modulo 2^32, so the sum may wrap through zero.
- R6: A window matches only when (control & M) equals (`lkMode` & M). For the outbound variant (default), M covers bits 18:16 (space code: 0 short, 1 standard, 2 extended), bit 14 (program) and bit 12 (supervisor). For the inbound variant, M covers bits 18:16 and bits 23 (program), 22 (data), 21 (supervisor) and 20 (user). Other bits of `lkMode` have no effect.
- R7: Control bits 30 (posted write) and 29 (prefetch read) are stored and read back, but do not change decode.
- R8: When several windows match, the lowest-numbered one is reported.
- R9: `resValid` is 1 exactly in the cycle after a cycle with `lkValid`. With it come `resHit`, `resWin` and `resAddr`. On a miss, `resWin` is 0 and `resAddr` equals the lookup address. Lookups may be issued on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | ADDR_W | Register word address |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr` |
| lkValid | input | 1 | Lookup request |
| lkAddr | input | 32 | Address to translate |
| lkMode | input | 32 | Requested mode, in control-word bit positions |
| resValid | output | 1 | Lookup result valid |
| resHit | output | 1 | A window matched |
| resWin | output | 3 | Index of the chosen window |
| resAddr | output | 32 | Translated address, or the lookup address on a miss |

## Verification
A register write and a lookup can land in the same cycle. The decode samples the window contents from before the clock edge, so the write only takes effect for later lookups. The bench provokes this case on a window whose limits are already programmed. In one cycle it writes the enable bit and issues a lookup into that window, and it expects a miss. A lookup issued on the very next cycle must then hit.

// File: rtl/xlatPkg.sv
package xlatPkg;
  localparam int WIN_CNT   = 8;
  localparam int WIN_IDX_W = $clog2(WIN_CNT);
  localparam int XW        = 32;
  localparam int FIELD_CNT = 4;
  localparam int EN_BIT    = 31;

  typedef enum logic [1:0] {
    FLD_CTRL   = 2'd0,
    FLD_LOWER  = 2'd1,
    FLD_UPPER  = 2'd2,
    FLD_OFFSET = 2'd3
  } fieldSel_t;

  typedef struct packed {
    logic                 wrStb;
    logic                 selHit;
    logic [WIN_IDX_W-1:0] selWin;
    fieldSel_t            selFld;
    logic                 lkStb;
  } winStrobe_t;
endpackage

// File: rtl/xlatWinCtrl.sv
module xlatWinCtrl
  import xlatPkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int LO_BASE = 'h40,
  parameter int HI_BASE = 'h68,
  parameter int STRIDE  = 5
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              lkValid,
  output winStrobe_t        strb
);
  localparam int HALF = WIN_CNT / 2;

  always_comb begin
    int addrI;
    int base;
    strb  = '0;
    addrI = int'(regAddr);
    for (int w = 0; w < WIN_CNT; w++) begin
      base = (w < HALF) ? (LO_BASE + STRIDE * w) : (HI_BASE + STRIDE * (w - HALF));
      if (addrI >= base && addrI < base + FIELD_CNT) begin
        strb.selHit = 1'b1;
        strb.selWin = WIN_IDX_W'(w);
        strb.selFld = fieldSel_t'(2'(addrI - base));
      end
    end
    strb.wrStb = regWrEn & strb.selHit;
    strb.lkStb = lkValid;
  end
endmodule

// File: rtl/xlatWinPath.sv
module xlatWinPath
  import xlatPkg::*;
#(
  parameter int INBOUND     = 0,
  parameter int FINE_BITS   = 12,
  parameter int COARSE_BITS = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  winStrobe_t           strb,
  input  logic [XW-1:0]        regWrData,
  output logic [XW-1:0]        regRdData,
  input  logic [XW-1:0]        lkAddr,
  input  logic [XW-1:0]        lkMode,
  output logic                 resValid,
  output logic                 resHit,
  output logic [WIN_IDX_W-1:0] resWin,
  output logic [XW-1:0]        resAddr
);
  localparam int HALF = WIN_CNT / 2;

  logic [XW-1:0] modeMask;
  generate
    if (INBOUND != 0) begin : g_inMask
      assign modeMask = 32'h00F7_0000;
    end else begin : g_outMask
      assign modeMask = 32'h0007_5000;
    end
  endgenerate

  logic [XW-1:0] ctrlQ  [WIN_CNT];
  logic [XW-1:0] lowerQ [WIN_CNT];
  logic [XW-1:0] upperQ [WIN_CNT];
  logic [XW-1:0] offQ   [WIN_CNT];
  logic [WIN_CNT-1:0] winHit;
  logic [XW-1:0] winXl  [WIN_CNT];

  generate
    for (genvar w = 0; w < WIN_CNT; w++) begin : g_win
      localparam int LOWB = ((w % HALF) == 0) ? FINE_BITS : COARSE_BITS;
      localparam logic [XW-1:0] KEEP = ~((XW'(1) << LOWB) - XW'(1));

      always_ff @(posedge clk) begin
        if (!rstN) begin
          ctrlQ[w]  <= '0;
          lowerQ[w] <= '0;
          upperQ[w] <= '0;
          offQ[w]   <= '0;
        end else if (strb.wrStb && strb.selWin == WIN_IDX_W'(w)) begin
          case (strb.selFld)
            FLD_CTRL:   ctrlQ[w]  <= regWrData;
            FLD_LOWER:  lowerQ[w] <= regWrData;
            FLD_UPPER:  upperQ[w] <= regWrData;
            FLD_OFFSET: offQ[w]   <= regWrData;
            default:    ;
          endcase
        end
      end

      logic modeOk;
      logic rangeOk;
      assign modeOk    = (ctrlQ[w] & modeMask) == (lkMode & modeMask);
      assign rangeOk   = (lkAddr >= (lowerQ[w] & KEEP)) && (lkAddr < (upperQ[w] & KEEP));
      assign winHit[w] = ctrlQ[w][EN_BIT] && modeOk && rangeOk;
      assign winXl[w]  = lkAddr + (offQ[w] & KEEP);
    end
  endgenerate

  logic                 pickHit;
  logic [WIN_IDX_W-1:0] pickWin;
  logic [XW-1:0]        pickAddr;

  always_comb begin
    pickHit  = 1'b0;
    pickWin  = '0;
    pickAddr = lkAddr;
    for (int w = WIN_CNT - 1; w >= 0; w--) begin
      if (winHit[w]) begin
        pickHit  = 1'b1;
        pickWin  = WIN_IDX_W'(w);
        pickAddr = winXl[w];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid <= 1'b0;
      resHit   <= 1'b0;
      resWin   <= '0;
      resAddr  <= '0;
    end else begin
      resValid <= strb.lkStb;
      resHit   <= strb.lkStb & pickHit;
      if (strb.lkStb) begin
        resWin  <= pickWin;
        resAddr <= pickAddr;
      end
    end
  end

  always_comb begin
    regRdData = '0;
    if (strb.selHit) begin
      case (strb.selFld)
        FLD_CTRL:   regRdData = ctrlQ[strb.selWin];
        FLD_LOWER:  regRdData = lowerQ[strb.selWin];
        FLD_UPPER:  regRdData = upperQ[strb.selWin];
        FLD_OFFSET: regRdData = offQ[strb.selWin];
        default:    regRdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/xlatWindows.sv
module xlatWindows
  import xlatPkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int LO_BASE     = 'h40,
  parameter int HI_BASE     = 'h68,
  parameter int STRIDE      = 5,
  parameter int INBOUND     = 0,
  parameter int FINE_BITS   = 12,
  parameter int COARSE_BITS = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWrEn,
  input  logic [XW-1:0]        regWrData,
  output logic [XW-1:0]        regRdData,
  input  logic                 lkValid,
  input  logic [XW-1:0]        lkAddr,
  input  logic [XW-1:0]        lkMode,
  output logic                 resValid,
  output logic                 resHit,
  output logic [WIN_IDX_W-1:0] resWin,
  output logic [XW-1:0]        resAddr
);
  winStrobe_t strb;

  xlatWinCtrl #(
    .ADDR_W (ADDR_W),
    .LO_BASE(LO_BASE),
    .HI_BASE(HI_BASE),
    .STRIDE (STRIDE)
  ) u_ctrl (
    .regAddr(regAddr),
    .regWrEn(regWrEn),
    .lkValid(lkValid),
    .strb   (strb)
  );

  xlatWinPath #(
    .INBOUND    (INBOUND),
    .FINE_BITS  (FINE_BITS),
    .COARSE_BITS(COARSE_BITS)
  ) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .regWrData(regWrData),
    .regRdData(regRdData),
    .lkAddr   (lkAddr),
    .lkMode   (lkMode),
    .resValid (resValid),
    .resHit   (resHit),
    .resWin   (resWin),
    .resAddr  (resAddr)
  );
endmodule

// File: rtl/xlatWindowsChk.sv
module xlatWindowsChk
  import xlatPkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 lkValid,
  input logic [XW-1:0]        lkAddr,
  input logic                 resValid,
  input logic                 resHit,
  input logic [WIN_IDX_W-1:0] resWin,
  input logic [XW-1:0]        resAddr
);
  AST_RES_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |=> resValid);                                                  // R9
  AST_RES_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |=> !resValid);                                                // R9
  AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    resHit |-> resValid);                                                   // R5
  AST_MISS_PASSTHRU: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |=> (resHit || resAddr == $past(lkAddr)));                      // R9
  AST_MISS_WIN_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !resHit) |-> resWin == '0);                                // R9
endmodule

bind xlatWindows xlatWindowsChk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .lkValid (lkValid),
  .lkAddr  (lkAddr),
  .resValid(resValid),
  .resHit  (resHit),
  .resWin  (resWin),
  .resAddr (resAddr)
);

// File: tb/xlatWindows_tb.sv
module xlatWindows_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        lkValid = 1'b0;
  logic [31:0] lkAddr = '0;
  logic [31:0] lkMode = '0;
  logic        resValid;
  logic        resHit;
  logic [2:0]  resWin;
  logic [31:0] resAddr;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  typedef struct packed {
    logic        hit;
    logic [2:0]  win;
    logic [31:0] addr;
  } exp_t;

  exp_t  expQ[$];
  string tagQ[$];

  always #10 clk = ~clk;

  xlatWindows u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .lkValid(lkValid),
    .lkAddr(lkAddr), .lkMode(lkMode), .resValid(resValid), .resHit(resHit),
    .resWin(resWin), .resAddr(resAddr)
  );

  function automatic int gb(int w);
    return (w < 4) ? ('h40 + 5 * w) : ('h68 + 5 * (w - 4));
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wrReg(int a, logic [31:0] d);
    @(negedge clk);
    regAddr = 8'(a); regWrData = d; regWrEn = 1'b1; lkValid = 1'b0;
  endtask

  task automatic rdCheck(string tag, int a, logic [31:0] exp);
    @(negedge clk);
    regAddr = 8'(a); regWrEn = 1'b0; lkValid = 1'b0;
    #1 check(tag, 64'(regRdData), 64'(exp));
  endtask

  task automatic lookup(string tag, logic [31:0] a, logic [31:0] m,
                        logic h, logic [2:0] w, logic [31:0] xa);
    exp_t e;
    @(negedge clk);
    regWrEn = 1'b0; lkValid = 1'b1; lkAddr = a; lkMode = m;
    e.hit = h; e.win = h ? w : 3'd0; e.addr = h ? xa : a;
    expQ.push_back(e); tagQ.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    regWrEn = 1'b0; lkValid = 1'b0;
  endtask

  // monitor: pops the expected item for every result the design produces
  always @(negedge clk) begin
    if (rstN && resValid) begin
      if (expQ.size() == 0) begin
        check("R9 unexpected result", 64'(resValid), 64'(0));
      end else begin
        exp_t e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check({t, " hit"}, 64'(resHit), 64'(e.hit));
        check({t, " win"}, 64'(resWin), 64'(e.win));
        check({t, " addr"}, 64'(resAddr), 64'(e.addr));
      end
    end
  end

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check("watchdog expired", 64'(1), 64'(0));
    finish();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R2 reset state
    #1 check("R2 resValid after reset", 64'(resValid), 64'(0));
    check("R2 resHit after reset", 64'(resHit), 64'(0));
    for (int f = 0; f < 4; f++) rdCheck("R2 window2 word zero", gb(2) + f, 32'h0);
    lookup("R2 R3 all disabled miss", 32'h0000_0000, 32'h0, 1'b0, 3'd0, 32'h0);

    // window 2: extended space, data, user
    wrReg(gb(2) + 1, 32'h8000_0000);
    wrReg(gb(2) + 2, 32'h8010_0000);
    wrReg(gb(2) + 3, 32'h1000_0000);
    wrReg(gb(2) + 0, 32'h8002_0000);
    rdCheck("R1 readback ctrl", gb(2) + 0, 32'h8002_0000);
    rdCheck("R1 readback offset", gb(2) + 3, 32'h1000_0000);
    lookup("R5 inside window", 32'h8000_1234, 32'h0002_0000, 1'b1, 3'd2, 32'h9000_1234);
    lookup("R5 upper limit exclusive", 32'h8010_0000, 32'h0002_0000, 1'b0, 3'd0, 32'h0);
    lookup("R5 below lower limit", 32'h7FFF_FFFF, 32'h0002_0000, 1'b0, 3'd0, 32'h0);
    lookup("R6 wrong space code", 32'h8000_1234, 32'h0001_0000, 1'b0, 3'd0, 32'h0);

    // window 5: wrapping offset
    wrReg(gb(5) + 1, 32'hF000_0000);
    wrReg(gb(5) + 2, 32'hF100_0000);
    wrReg(gb(5) + 3, 32'h2000_0000);
    wrReg(gb(5) + 0, 32'h8002_0000);
    lookup("R5 offset wraps", 32'hF000_0010, 32'h0002_0000, 1'b1, 3'd5, 32'h1000_0010);

    // window 0: fine granularity, short space, supervisor
    wrReg(gb(0) + 1, 32'h0000_1FFF);
    wrReg(gb(0) + 2, 32'h0000_3ABC);
    wrReg(gb(0) + 3, 32'h0000_0123);
    wrReg(gb(0) + 0, 32'h8000_1000);
    rdCheck("R1 readback unmasked lower", gb(0) + 1, 32'h0000_1FFF);
    lookup("R4 fine lower cleared", 32'h0000_1000, 32'h0000_1000, 1'b1, 3'd0, 32'h0000_1000);
    lookup("R4 fine upper cleared", 32'h0000_2FFF, 32'h0000_1000, 1'b1, 3'd0, 32'h0000_2FFF);
    lookup("R4 fine upper exclusive", 32'h0000_3000, 32'h0000_1000, 1'b0, 3'd0, 32'h0);

    // window 1: coarse granularity, standard space, program
    wrReg(gb(1) + 1, 32'h0004_8000);
    wrReg(gb(1) + 2, 32'h0006_0000);
    wrReg(gb(1) + 3, 32'h0001_F000);
    wrReg(gb(1) + 0, 32'h8001_4000);
    lookup("R4 coarse masks", 32'h0004_0000, 32'h0001_4000, 1'b1, 3'd1, 32'h0005_0000);
    lookup("R6 program bit mismatch", 32'h0004_0000, 32'h0001_0000, 1'b0, 3'd0, 32'h0);

    // window 3 overlaps window 1
    wrReg(gb(3) + 1, 32'h0004_0000);
    wrReg(gb(3) + 2, 32'h0006_0000);
    wrReg(gb(3) + 3, 32'h0000_0000);
    wrReg(gb(3) + 0, 32'h8001_4000);
    lookup("R8 lowest index wins", 32'h0004_0000, 32'h0001_4000, 1'b1, 3'd1, 32'h0005_0000);
    wrReg(gb(1) + 0, 32'h0001_4000);
    lookup("R3 disabled window skipped", 32'h0004_0000, 32'h0001_4000, 1'b1, 3'd3, 32'h0004_0000);
    lookup("R6 unmasked mode bit ignored", 32'h0004_0000, 32'h0001_6000, 1'b1, 3'd3, 32'h0004_0000);

    // R7 posted-write and prefetch bits
    wrReg(gb(3) + 0, 32'hE001_4000);
    rdCheck("R7 readback extra bits", gb(3) + 0, 32'hE001_4000);
    lookup("R7 extra bits no effect", 32'h0005_0000, 32'h0001_4000, 1'b1, 3'd3, 32'h0005_0000);

    // R1 unmapped words
    wrReg(gb(0) + 4, 32'hDEAD_BEEF);
    rdCheck("R1 spare word reads zero", gb(0) + 4, 32'h0);
    wrReg('h54, 32'hCAFE_F00D);
    rdCheck("R1 unmapped reads zero", 'h54, 32'h0);
    rdCheck("R1 window0 ctrl untouched", gb(0) + 0, 32'h8000_1000);
    wrReg(gb(4) + 1, 32'h1234_5678);
    rdCheck("R1 high group readback", gb(4) + 1, 32'h1234_5678);

    // same-cycle write and lookup on window 6
    wrReg(gb(6) + 1, 32'hA000_0000);
    wrReg(gb(6) + 2, 32'hA001_0000);
    @(negedge clk);
    regAddr = 8'(gb(6)); regWrData = 32'h8002_0000; regWrEn = 1'b1;
    lkValid = 1'b1; lkAddr = 32'hA000_0040; lkMode = 32'h0002_0000;
    expQ.push_back('{hit: 1'b0, win: 3'd0, addr: 32'hA000_0040});
    tagQ.push_back("R9 same-cycle write not seen");
    lookup("R3 enable seen next cycle", 32'hA000_0040, 32'h0002_0000, 1'b1, 3'd6, 32'hA000_0040);

    // R9 back-to-back lookups
    lookup("R9 back-to-back a", 32'h8000_0000, 32'h0002_0000, 1'b1, 3'd2, 32'h9000_0000);
    lookup("R9 back-to-back b", 32'hF0FF_FFFF, 32'h0002_0000, 1'b1, 3'd5, 32'h10FF_FFFF);
    lookup("R9 back-to-back c", 32'h0000_0FFF, 32'h0000_1000, 1'b0, 3'd0, 32'h0);
    idle();
    #1 check("R9 result follows last lookup", 64'(resValid), 64'(1));
    idle();
    #1 check("R9 no result without request", 64'(resValid), 64'(0));
    repeat (2) idle();
    check("R9 all results produced", 64'(expQ.size()), 64'(0));
    finish();
  end
endmodule